// File: doc/BRIEF.md
# Privileged-Mode Exception Entry Unit

This unit steers the program counter of a simple in-order core when a trap is taken and when the privileged return command executes. A fault strobe carries a five-bit fault code. The unit forms the handler address from the privileged base input plus a fixed per-fault offset. It captures a restart address according to the fault class and the current privilege mode. It also switches the shadow register bank in when the core enters from unprivileged code.

The return strobe sends the core back to the saved restart address. It also pulses a request to re-examine pending interrupts. Bit 0 of the restart address records whether the core returns into privileged code. When that bit is 0, the shadow bank is switched back out. A return issued outside privileged mode is not honoured; the unit takes an unimplemented-opcode trap instead.

A small combinational lookup tells the register file whether a given architectural register index is currently served by its shadow copy. All results other than that lookup are registered and appear one clock after the strobe.

Top module: `trap_entry_unit`

## Requirements
- R1: While reset is asserted and after it is released with no strobe, `shadow_sel` is 1, `next_pc` is RESET_BASE+0x1, `next_npc` is `next_pc`+4, `restart_addr` is 0, and `redirect`, `intr_recheck`, `swap_err` and `unsup` are 0.
- R2: A fault strobe with a valid code (1 to 16) sets `next_pc` to `priv_base` plus that code's offset and `next_npc` to `next_pc`+4, with `redirect` high for one cycle, all in the cycle after the strobe.
- R3: Fault codes and offsets are: 1 reset 0x0001, 2 machine check 0x0401, 3 arithmetic 0x0501, 4 interrupt 0x0101, 5 native data-TLB miss 0x0201, 6 privileged data-TLB miss 0x0281, 7 alignment 0x0301, 8 data-TLB fault 0x0381, 9 data-TLB access violation 0x0381, 10 instruction-TLB miss 0x0181, 11 instruction-TLB fault 0x0181, 12 instruction-TLB access violation 0x0081, 13 unimplemented opcode 0x0481, 14 FP disabled 0x0581, 15 privileged call 0x2001, 16 integer overflow 0x0501.
- R4: A taken fault loads `restart_addr` with `cur_pc`, except for an interrupt (code 4) taken while `in_priv` is 1, which leaves `restart_addr` unchanged.
- R5: For the privileged call (code 15) and arithmetic (code 3), `restart_addr` receives `cur_pc`+4; integer overflow (code 16) is not advanced.
- R6: A trap taken while `in_priv` is 0 sets `shadow_sel` to 1; a trap taken while `in_priv` is 1 leaves `shadow_sel` unchanged.
- R7: A return strobe with `in_priv` 1 and no taken fault sets `next_pc` to `restart_addr` and `next_npc` to `restart_addr`+4, and pulses `redirect` and `intr_recheck`. It clears `shadow_sel` only if bit 0 of `restart_addr` is 0.
- R8: A return strobe with `in_priv` 0 and no taken fault acts as an unimplemented-opcode trap (offset 0x0481, `restart_addr` = `cur_pc`, shadow bank switched in) and does not pulse `intr_recheck`.
- R9: `swap_err` pulses for one cycle when a trap from `in_priv` 0 finds `shadow_sel` already 1, or when a return that clears the bank finds `shadow_sel` already 0.
- R10: When a valid fault and a return strobe arrive in the same cycle, only the fault is acted on.
- R11: `reg_shadowed` is 1 exactly when `shadow_sel` is 1 and `reg_idx` is one of 8, 9, 10, 11, 12, 13, 14 or 25, in the same cycle.
- R12: A fault strobe with code 0 or 17 to 31 is ignored: no output changes, no `redirect`, and a return strobe in the same cycle proceeds as if no fault strobe were present.
- R13: A taken arithmetic fault (code 3) pulses `unsup` in the cycle after the strobe while still performing the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_valid | input | 1 | Fault strobe |
| fault_code | input | 5 | Fault class of the strobe |
| cur_pc | input | AW | Address of the current instruction |
| rei_valid | input | 1 | Return-from-exception strobe |
| in_priv | input | 1 | Core is executing privileged code |
| priv_base | input | AW | Base of the privileged handler area |
| reg_idx | input | RW | Register index for the shadow lookup |
| next_pc | output | AW | Redirect target |
| next_npc | output | AW | Redirect target plus 4 |
| redirect | output | 1 | One-cycle pulse: take `next_pc` |
| restart_addr | output | AW | Saved exception restart address |
| shadow_sel | output | 1 | Shadow bank active |
| reg_shadowed | output | 1 | `reg_idx` currently maps to its shadow copy |
| intr_recheck | output | 1 | Pulse after a return: re-examine interrupts |
| swap_err | output | 1 | Pulse on a bank swap into the current state |
| unsup | output | 1 | Pulse on an unsupported arithmetic trap |

## Verification
The bench builds the unit with AW = 32, NREG = 32, RESET_BASE = 0x8000 and the default shadow mask. At 32 bits, a randomly drawn `priv_base` near the top of the space makes base-plus-offset and restart-plus-4 wrap. The reference model must then match modulo 2^32. All 32 register indices are probed against both bank states, so every masked and unmasked position of the sparse shadow set is visited. All 32 code values are drawn, so both the 16 valid offsets and every ignored code are compared.

// File: rtl/trap_entry_unit.sv
module trap_entry_unit #(
  parameter int          AW          = 32,
  parameter int          NREG        = 32,
  parameter logic [AW-1:0] RESET_BASE = 32'h0000_8000,
  parameter logic [NREG-1:0] SHADOW_MASK = 32'h0200_7F00,
  localparam int         RW          = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fault_valid,
  input  logic [4:0]    fault_code,
  input  logic [AW-1:0] cur_pc,
  input  logic          rei_valid,
  input  logic          in_priv,
  input  logic [AW-1:0] priv_base,
  input  logic [RW-1:0] reg_idx,
  output logic [AW-1:0] next_pc,
  output logic [AW-1:0] next_npc,
  output logic          redirect,
  output logic [AW-1:0] restart_addr,
  output logic          shadow_sel,
  output logic          reg_shadowed,
  output logic          intr_recheck,
  output logic          swap_err,
  output logic          unsup
);

  localparam logic [4:0] C_RESET = 5'd1;
  localparam logic [4:0] C_ARITH = 5'd3;
  localparam logic [4:0] C_INTR  = 5'd4;
  localparam logic [4:0] C_UNIMP = 5'd13;
  localparam logic [4:0] C_PCALL = 5'd15;
  localparam logic [4:0] C_LAST  = 5'd16;
  localparam logic [AW-1:0] STEP = AW'(4);

  function automatic logic [15:0] vec_off(input logic [4:0] c);
    case (c)
      5'd1:          vec_off = 16'h0001;
      5'd2:          vec_off = 16'h0401;
      5'd3, 5'd16:   vec_off = 16'h0501;
      5'd4:          vec_off = 16'h0101;
      5'd5:          vec_off = 16'h0201;
      5'd6:          vec_off = 16'h0281;
      5'd7:          vec_off = 16'h0301;
      5'd8, 5'd9:    vec_off = 16'h0381;
      5'd10, 5'd11:  vec_off = 16'h0181;
      5'd12:         vec_off = 16'h0081;
      5'd13:         vec_off = 16'h0481;
      5'd14:         vec_off = 16'h0581;
      5'd15:         vec_off = 16'h2001;
      default:       vec_off = 16'h0000;
    endcase
  endfunction

  logic          code_ok, take_fault, bad_ret, good_ret, entry;
  logic          keep_ra, skip, swap_in, swap_out;
  logic [4:0]    eff_code;
  logic [AW-1:0] tgt;

  assign code_ok    = (fault_code != 5'd0) && (fault_code <= C_LAST);
  assign take_fault = fault_valid && code_ok;
  assign bad_ret    = rei_valid && !take_fault && !in_priv;
  assign good_ret   = rei_valid && !take_fault && in_priv;
  assign entry      = take_fault || bad_ret;
  assign eff_code   = take_fault ? fault_code : C_UNIMP;
  assign tgt        = priv_base + AW'(vec_off(eff_code));
  assign keep_ra    = take_fault && (fault_code == C_INTR) && in_priv;
  assign skip       = take_fault && ((fault_code == C_ARITH) || (fault_code == C_PCALL));
  assign swap_in    = entry && !in_priv;
  assign swap_out   = good_ret && !restart_addr[0];

  assign reg_shadowed = shadow_sel && SHADOW_MASK[reg_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_pc      <= RESET_BASE + AW'(vec_off(C_RESET));
      next_npc     <= RESET_BASE + AW'(vec_off(C_RESET)) + STEP;
      restart_addr <= '0;
      shadow_sel   <= 1'b1;
      redirect     <= 1'b0;
      intr_recheck <= 1'b0;
      swap_err     <= 1'b0;
      unsup        <= 1'b0;
    end else begin
      redirect     <= entry || good_ret;
      intr_recheck <= good_ret;
      unsup        <= take_fault && (fault_code == C_ARITH);
      swap_err     <= (swap_in && shadow_sel) || (swap_out && !shadow_sel);
      if (entry) begin
        next_pc  <= tgt;
        next_npc <= tgt + STEP;
        if (!keep_ra) restart_addr <= skip ? cur_pc + STEP : cur_pc;
        if (swap_in) shadow_sel <= 1'b1;
      end else if (good_ret) begin
        next_pc  <= restart_addr;
        next_npc <= restart_addr + STEP;
        if (swap_out) shadow_sel <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/trap_entry_unit_chk.sv
module trap_entry_unit_chk #(
  parameter int AW = 32,
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fault_valid,
  input logic [4:0]    fault_code,
  input logic          rei_valid,
  input logic          in_priv,
  input logic [AW-1:0] next_pc,
  input logic [AW-1:0] next_npc,
  input logic          redirect,
  input logic [AW-1:0] restart_addr,
  input logic          shadow_sel,
  input logic          reg_shadowed,
  input logic          intr_recheck
);

  logic good_code;
  assign good_code = (fault_code >= 5'd1) && (fault_code <= 5'd16);

  a_r2_entry_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && good_code) |=> (redirect && next_npc == next_pc + AW'(4)));

  a_r4_intr_keeps_ra: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && fault_code == 5'd4 && in_priv) |=> $stable(restart_addr));

  a_r6_swap_in: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && good_code && !in_priv) |=> shadow_sel);

  a_r7_return_target: assert property (@(posedge clk) disable iff (!rst_n)
    (rei_valid && !fault_valid && in_priv) |=> (next_pc == $past(restart_addr) && intr_recheck));

  a_r10_fault_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && good_code && rei_valid) |=> !intr_recheck);

  a_r11_lookup_needs_bank: assert property (@(posedge clk) disable iff (!rst_n)
    reg_shadowed |-> shadow_sel);

  a_r12_code_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && !good_code && !rei_valid) |=> (!redirect && $stable(next_pc) && $stable(restart_addr)));

endmodule

bind trap_entry_unit trap_entry_unit_chk #(.AW(AW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fault_valid(fault_valid), .fault_code(fault_code),
  .rei_valid(rei_valid), .in_priv(in_priv), .next_pc(next_pc), .next_npc(next_npc),
  .redirect(redirect), .restart_addr(restart_addr), .shadow_sel(shadow_sel),
  .reg_shadowed(reg_shadowed), .intr_recheck(intr_recheck)
);

// File: tb/trap_entry_unit_tb_top.sv
`timescale 1ns/1ps
module trap_entry_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fault_valid = 1'b0;
  logic [4:0]  fault_code = '0;
  logic [31:0] cur_pc = '0;
  logic        rei_valid = 1'b0;
  logic        in_priv = 1'b0;
  logic [31:0] priv_base = '0;
  logic [4:0]  reg_idx = '0;
  logic [31:0] next_pc, next_npc, restart_addr;
  logic        redirect, shadow_sel, reg_shadowed, intr_recheck, swap_err, unsup;

  always #2 clk = ~clk;

  trap_entry_unit dut_i (
    .clk(clk), .rst_n(rst_n), .fault_valid(fault_valid), .fault_code(fault_code),
    .cur_pc(cur_pc), .rei_valid(rei_valid), .in_priv(in_priv), .priv_base(priv_base),
    .reg_idx(reg_idx), .next_pc(next_pc), .next_npc(next_npc), .redirect(redirect),
    .restart_addr(restart_addr), .shadow_sel(shadow_sel), .reg_shadowed(reg_shadowed),
    .intr_recheck(intr_recheck), .swap_err(swap_err), .unsup(unsup)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] m_pc, m_npc, m_ra;
  bit m_sh, m_red, m_rc, m_err, m_uns;

  function automatic int off_of(input int c);
    case (c)
      1: return 'h0001;   2: return 'h0401;   3: return 'h0501;   4: return 'h0101;
      5: return 'h0201;   6: return 'h0281;   7: return 'h0301;   8: return 'h0381;
      9: return 'h0381;   10: return 'h0181;  11: return 'h0181;  12: return 'h0081;
      13: return 'h0481;  14: return 'h0581;  15: return 'h2001;  16: return 'h0501;
      default: return -1;
    endcase
  endfunction

  function automatic bit in_shadow_set(input int i);
    return (i >= 8 && i <= 14) || i == 25;
  endfunction

  task automatic cmp(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", rq, what, act, exp, $time);
    end
  endtask

  task automatic cmp_all(input string rq);
    cmp(rq, "next_pc", next_pc, m_pc);
    cmp(rq, "next_npc", next_npc, m_npc);
    cmp(rq, "restart_addr", restart_addr, m_ra);
    cmp(rq, "shadow_sel", {31'b0, shadow_sel}, {31'b0, m_sh});
    cmp(rq, "redirect", {31'b0, redirect}, {31'b0, m_red});
    cmp(rq, "intr_recheck", {31'b0, intr_recheck}, {31'b0, m_rc});
    cmp(rq, "swap_err", {31'b0, swap_err}, {31'b0, m_err});
    cmp(rq, "unsup", {31'b0, unsup}, {31'b0, m_uns});
  endtask

  task automatic step(input bit fv, input int fc, input logic [31:0] pc, input bit rv,
                      input bit ip, input logic [31:0] base, input int ri, input string rq);
    int o;
    bit tf, bad, good, ent, sw_in, sw_out;
    logic [31:0] tgt;
    @(negedge clk);
    fault_valid = fv; fault_code = 5'(fc); cur_pc = pc; rei_valid = rv;
    in_priv = ip; priv_base = base; reg_idx = 5'(ri);
    #1;
    cmp("R11", "reg_shadowed", {31'b0, reg_shadowed}, {31'b0, (m_sh && in_shadow_set(ri))});
    o = off_of(fc);
    tf = fv && (o >= 0);
    bad = rv && !tf && !ip;
    good = rv && !tf && ip;
    ent = tf || bad;
    sw_in = ent && !ip;
    sw_out = good && (m_ra[0] == 1'b0);
    m_red = ent || good;
    m_rc = good;
    m_uns = tf && fc == 3;
    m_err = (sw_in && m_sh) || (sw_out && !m_sh);
    if (ent) begin
      tgt = base + 32'(tf ? o : 'h0481);
      m_pc = tgt;
      m_npc = tgt + 32'd4;
      if (!(tf && fc == 4 && ip))
        m_ra = (tf && (fc == 3 || fc == 15)) ? pc + 32'd4 : pc;
      if (sw_in) m_sh = 1'b1;
    end else if (good) begin
      m_pc = m_ra;
      m_npc = m_ra + 32'd4;
      if (sw_out) m_sh = 1'b0;
    end
    @(posedge clk);
    #1;
    cmp_all(rq);
  endtask

  initial begin
    m_pc = 32'h8001; m_npc = 32'h8005; m_ra = '0;
    m_sh = 1'b1; m_red = 0; m_rc = 0; m_err = 0; m_uns = 0;
    repeat (3) @(posedge clk);
    #1; cmp_all("R1");
    @(negedge clk); rst_n = 1'b1;
    #1; cmp_all("R1");

    step(0, 0, 0, 1, 1, 32'h10000, 9, "R7");
    step(1, 5, 32'h100, 0, 0, 32'h10000, 9, "R2");
    step(0, 0, 0, 0, 1, 32'h10000, 25, "R6");
    step(1, 4, 32'h180, 0, 1, 32'h10000, 15, "R4");
    step(1, 4, 32'h190, 0, 0, 32'h10000, 7, "R4");
    step(1, 15, 32'h200, 0, 1, 32'h10000, 8, "R5");
    step(1, 3, 32'h240, 0, 1, 32'h10000, 14, "R13");
    step(1, 16, 32'h280, 0, 1, 32'h10000, 0, "R5");
    for (int c = 1; c <= 16; c++) step(1, c, 32'h400 + 32'(c * 8), 0, 1, 32'h20000, c, "R3");
    step(1, 7, 32'h301, 0, 1, 32'h10000, 10, "R7");
    step(0, 0, 0, 1, 1, 32'h10000, 10, "R7");
    step(1, 7, 32'h300, 0, 1, 32'h10000, 10, "R7");
    step(0, 0, 0, 1, 1, 32'h10000, 12, "R7");
    step(0, 0, 0, 1, 1, 32'h10000, 12, "R9");
    step(1, 2, 32'h500, 0, 0, 32'h10000, 13, "R6");
    step(1, 2, 32'h540, 0, 0, 32'h10000, 13, "R9");
    step(0, 0, 32'h600, 1, 0, 32'h10000, 11, "R8");
    step(1, 10, 32'h700, 1, 1, 32'h10000, 11, "R10");
    step(1, 0, 32'h780, 0, 1, 32'h10000, 26, "R12");
    step(1, 20, 32'h7c0, 0, 0, 32'h10000, 24, "R12");
    step(1, 31, 32'h7e0, 1, 1, 32'h10000, 8, "R12");
    step(1, 6, 32'hFFFF_FFFC, 0, 0, 32'hFFFF_FF00, 25, "R2");
    for (int k = 0; k < 3000; k++)
      step($urandom_range(0, 1), $urandom_range(0, 31), $urandom, $urandom_range(0, 1),
           $urandom_range(0, 1), $urandom & 32'hFFFF_F000, $urandom_range(0, 31), "R2");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule